// File: doc/BRIEF.md
# Occupancy-Flagged Single-Clock FIFO

This block is a first-in first-out buffer with one clock. It holds words in a two-port storage array. Two independent wrapping counters supply the addresses: one for writes and one for reads. A write and a read can both be accepted on the same clock edge. The block drives three occupancy flags: full, empty and half-full. It also drives an interrupt line whose source is picked from those flags at run time.

A build-time parameter sets the behaviour when a write meets a full buffer. In overwrite mode the oldest word is dropped to make room, so the buffer always holds the newest DEPTH words. In refuse mode the write is discarded, and only a read frees a slot. In both modes, a write that arrives while full with no read beside it sets a sticky overflow bit. That bit stays set until it is cleared on purpose. This lets a consumer find out after the fact that data was lost or refused.

Top module: `occ_fifo`

## Requirements
- R1: Words leave in the order they were accepted. An accepted read presents the oldest stored word on rd_data_o one clock after the read edge, and rd_data_o holds that value until the next accepted read.
- R2: Starting from empty, with no reads, full_o rises after exactly DEPTH accepted writes. A single read with no write, done while full, drops full_o on the next cycle.
- R3: empty_o is high exactly when occupancy is zero. full_o and empty_o are never high together.
- R4: half_o is high exactly when occupancy is at least DEPTH/2.
- R5: With OVERWRITE=0, a write while full with no read is discarded. Stored contents and occupancy are unchanged.
- R6: With OVERWRITE=1, a write while full with no read discards the oldest word and stores the new word. Occupancy stays at DEPTH.
- R7: A read and a write in the same cycle are both accepted, including while full and in either mode. Occupancy is then unchanged, except from empty, where only the write takes effect.
- R8: A read while empty is ignored. rd_data_o keeps its previous value and the flags do not change.
- R9: ovf_o sets on the cycle after a write arrives while full with no read in the same cycle. It then stays high until ovf_clr_i is sampled high. If a set and a clear happen in the same cycle, the set wins.
- R10: irq_sel_i chooses the irq_o source: 0 selects full, 1 selects not-empty, 2 selects half-full, and 3 holds irq_o low.
- R11: After rst_ni is asserted, the block is empty: empty_o=1, and full_o, half_o, ovf_o and rd_data_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Last word read, registered |
| ovf_clr_i | input | 1 | Clears the overflow bit |
| irq_sel_i | input | 2 | Interrupt source select |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |
| half_o | output | 1 | Occupancy at least DEPTH/2 |
| ovf_o | output | 1 | Sticky overflow bit |
| irq_o | output | 1 | Selected interrupt source |

## Verification
The case that needs the most care is a read and a write landing on the same edge while the buffer is full. In that case the write slot and the read slot share one address. The read must still return the old word, and no overflow may be recorded. The bench drives both strobes together against a full buffer, in both the overwrite and the refuse configuration, for several consecutive cycles. A queue scoreboard judges each data word and each flag in the following cycle. A random mix of requests then produces the same collision at other fill levels, including the case from empty.

// File: rtl/occ_fifo_pkg.sv
package occ_fifo_pkg;
  typedef enum logic [1:0] {
    IRQ_FULL  = 2'd0,
    IRQ_AVAIL = 2'd1,
    IRQ_HALF  = 2'd2,
    IRQ_OFF   = 2'd3
  } irq_src_e;
endpackage

// File: rtl/occ_fifo_ptr.sv
module occ_fifo_ptr #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/occ_fifo_mem.sv
module occ_fifo_mem #(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read sees the pre-edge contents, so a same-address write does not bypass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/occ_fifo_flags.sv
module occ_fifo_flags
  import occ_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       dec_i,
  input  logic       ovf_set_i,
  input  logic       ovf_clr_i,
  input  logic [1:0] irq_sel_i,
  output logic       full_o,
  output logic       empty_o,
  output logic       half_o,
  output logic       ovf_o,
  output logic       irq_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);

  logic [CW-1:0] cnt_q;
  irq_src_e      src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (inc_i && !dec_i)   cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_o <= 1'b0;
    else if (ovf_set_i) ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  assign full_o  = (cnt_q == CNT_FULL);
  assign empty_o = (cnt_q == '0);
  assign half_o  = (cnt_q >= CNT_HALF);
  assign src     = irq_src_e'(irq_sel_i);

  always_comb begin
    unique case (src)
      IRQ_FULL:  irq_o = full_o;
      IRQ_AVAIL: irq_o = !empty_o;
      IRQ_HALF:  irq_o = half_o;
      default:   irq_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/occ_fifo.sv
module occ_fifo #(
  parameter int DATA_W    = 9,
  parameter int DEPTH     = 1024,
  parameter bit OVERWRITE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              ovf_clr_i,
  input  logic [1:0]        irq_sel_i,
  output logic              full_o,
  output logic              empty_o,
  output logic              half_o,
  output logic              ovf_o,
  output logic              irq_o
);
  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0] wr_ptr, rd_ptr;
  logic wr_acc, rd_acc, drop_old, collide;

  assign collide = wr_en_i && full_o && !rd_en_i;
  assign rd_acc  = rd_en_i && !empty_o;

  generate
    if (OVERWRITE) begin : g_overwrite
      assign wr_acc   = wr_en_i;
      assign drop_old = collide;
    end else begin : g_refuse
      assign wr_acc   = wr_en_i && !collide;
      assign drop_old = 1'b0;
    end
  endgenerate

  occ_fifo_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(wr_acc), .ptr_o(wr_ptr)
  );

  occ_fifo_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk_i (clk_i), .rst_ni(rst_ni), .adv_i(rd_acc || drop_old), .ptr_o(rd_ptr)
  );

  occ_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wr_acc),
    .waddr_i(wr_ptr),
    .wdata_i(wr_data_i),
    .re_i   (rd_acc),
    .raddr_i(rd_ptr),
    .rdata_o(rd_data_o)
  );

  occ_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (wr_acc && !drop_old),
    .dec_i    (rd_acc),
    .ovf_set_i(collide),
    .ovf_clr_i(ovf_clr_i),
    .irq_sel_i(irq_sel_i),
    .full_o   (full_o),
    .empty_o  (empty_o),
    .half_o   (half_o),
    .ovf_o    (ovf_o),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/occ_fifo_chk.sv
module occ_fifo_chk #(
  parameter int DATA_W    = 9,
  parameter bit OVERWRITE = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ovf_clr_i,
  input logic              full_o,
  input logic              empty_o,
  input logic              half_o,
  input logic              ovf_o
);
  a_r3_not_full_and_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));

  a_r4_full_is_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o);

  a_r2_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && rd_en_i && !wr_en_i |=> !full_o);

  a_r5_refuse_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !OVERWRITE && full_o && wr_en_i && !rd_en_i |=> full_o && $stable(rd_data_o));

  a_r7_both_while_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_en_i && rd_en_i |=> full_o);

  a_r8_empty_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && rd_en_i |=> $stable(rd_data_o));

  a_r9_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && wr_en_i && !rd_en_i |=> ovf_o);

  a_r9_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !ovf_clr_i |=> ovf_o);
endmodule

bind occ_fifo occ_fifo_chk #(.DATA_W(DATA_W), .OVERWRITE(OVERWRITE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .rd_en_i  (rd_en_i),
  .rd_data_o(rd_data_o),
  .ovf_clr_i(ovf_clr_i),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .half_o   (half_o),
  .ovf_o    (ovf_o)
);

// File: tb/tb_occ_fifo.sv
module tb_occ_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 9;
  localparam int D  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ovf_clr = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] irq_sel = 2'd0;

  logic [DW-1:0] rd_r, rd_o;
  logic full_r, empty_r, half_r, ovf_r, irq_r;
  logic full_o, empty_o, half_o, ovf_o, irq_o;

  int n_chk = 0, n_fail = 0;
  string tag = "R11";

  // scoreboard state for refuse (r) and overwrite (o) instances
  logic [DW-1:0] q_r[$], q_o[$];
  logic [DW-1:0] last_r = '0, last_o = '0;
  logic ov_r = 1'b0, ov_o = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  occ_fifo #(.DATA_W(DW), .DEPTH(D), .OVERWRITE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_r), .ovf_clr_i(ovf_clr), .irq_sel_i(irq_sel),
    .full_o(full_r), .empty_o(empty_r), .half_o(half_r), .ovf_o(ovf_r), .irq_o(irq_r)
  );

  occ_fifo #(.DATA_W(DW), .DEPTH(D), .OVERWRITE(1'b1)) dut_ow (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_data_o(rd_o), .ovf_clr_i(ovf_clr), .irq_sel_i(irq_sel),
    .full_o(full_o), .empty_o(empty_o), .half_o(half_o), .ovf_o(ovf_o), .irq_o(irq_o)
  );

  task automatic chk(string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic irq_of(int n);
    case (irq_sel)
      2'd0: return n == D;
      2'd1: return n != 0;
      2'd2: return n >= D/2;
      default: return 1'b0;
    endcase
  endfunction

  // monitor: compare every output of both instances against the scoreboard
  task automatic compare_all();
    chk("refuse data R1",   rd_r, last_r);
    chk("refuse full R2",   full_r, q_r.size() == D);
    chk("refuse empty R3",  empty_r, q_r.size() == 0);
    chk("refuse half R4",   half_r, q_r.size() >= D/2);
    chk("refuse ovf R9",    ovf_r, ov_r);
    chk("refuse irq R10",   irq_r, irq_of(q_r.size()));
    chk("ovrwr data R1",    rd_o, last_o);
    chk("ovrwr full R2",    full_o, q_o.size() == D);
    chk("ovrwr empty R3",   empty_o, q_o.size() == 0);
    chk("ovrwr half R4",    half_o, q_o.size() >= D/2);
    chk("ovrwr ovf R9",     ovf_o, ov_o);
    chk("ovrwr irq R10",    irq_o, irq_of(q_o.size()));
  endtask

  // driver: one cycle of stimulus, scoreboard update, then compare
  task automatic cyc(logic w, logic [DW-1:0] d, logic r, logic clr = 1'b0);
    logic fr, fo;
    wr_en = w; wr_data = d; rd_en = r; ovf_clr = clr;
    fr = (q_r.size() == D);
    fo = (q_o.size() == D);
    @(posedge clk);
    if (r && q_r.size() > 0) last_r = q_r.pop_front();
    if (w && !(fr && !r)) q_r.push_back(d);           // R5 refuse when full
    if (r && q_o.size() > 0) last_o = q_o.pop_front();
    if (w) begin
      if (q_o.size() == D) void'(q_o.pop_front());    // R6 drop oldest
      q_o.push_back(d);
    end
    if (w && fr && !r) ov_r = 1'b1; else if (clr) ov_r = 1'b0;
    if (w && fo && !r) ov_o = 1'b1; else if (clr) ov_o = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; ovf_clr = 1'b0;
    compare_all();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R11";
    compare_all();                       // reset state
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R8";                          // reads while empty ignored
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b1);

    tag = "R7";                          // simultaneous from empty: only write lands
    cyc(1'b1, 9'h0aa, 1'b1);

    tag = "R1";
    irq_sel = 2'd1;
    cyc(1'b1, 9'h011, 1'b0);
    cyc(1'b1, 9'h122, 1'b1);
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b1);                 // back to empty, data held (R8)

    tag = "R2";
    irq_sel = 2'd2;
    for (int i = 0; i < D; i++) begin
      if (i == D/2) irq_sel = 2'd0;
      cyc(1'b1, DW'(9'h100 + i), 1'b0);
    end

    tag = "R5";                          // writes while full: refuse vs overwrite (R6)
    cyc(1'b1, 9'h1e1, 1'b0);
    tag = "R6";
    cyc(1'b1, 9'h1e2, 1'b0, 1'b1);       // set wins over clear (R9)
    cyc(1'b1, 9'h1e3, 1'b0);

    tag = "R7";                          // read+write while full, both modes
    irq_sel = 2'd3;
    cyc(1'b1, 9'h0c1, 1'b1);
    cyc(1'b1, 9'h0c2, 1'b1);
    cyc(1'b1, 9'h0c3, 1'b1);

    tag = "R9";
    cyc(1'b0, '0, 1'b0);                 // sticky
    cyc(1'b0, '0, 1'b0, 1'b1);           // clear

    tag = "R2";                          // one read drops full
    irq_sel = 2'd0;
    cyc(1'b0, '0, 1'b1);

    tag = "R1";
    irq_sel = 2'd1;
    for (int i = 0; i < D + 2; i++) cyc(1'b0, '0, 1'b1);

    tag = "R10";
    for (int s = 0; s < 4; s++) begin
      irq_sel = 2'(s);
      cyc(1'b1, DW'(s), 1'b0);
    end

    tag = "R7";                          // random mix, collisions at all levels
    for (int i = 0; i < 400; i++) begin
      irq_sel = 2'($urandom_range(0, 3));
      cyc(1'($urandom_range(0, 2) != 0), DW'($urandom), 1'($urandom_range(0, 1)),
          1'($urandom_range(0, 7) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule